// File: doc/BRIEF.md
# Windowed Watchdog with Postscaler

This block is a watchdog timer that software must service with a clear strobe before a fixed number of postscaled ticks elapse. The raw tick comes either from every cycle of the peripheral bus clock or from a low-power RC tick pulse synchronised into the same clock domain. A 5-bit code sets the postscale division ratio. The main counter then counts postscaled ticks through a period of `2^PERIOD_LOG` steps. When the period completes, the block raises a one-cycle timeout event, and the reset controller outside the block acts on it.

In windowed operation a clear is accepted only in the final part of the period. A 2-bit code sets the size of that part as a fraction of the period. A clear that arrives too early raises a window-violation event and is otherwise discarded. A hardware enable forces the timer on, and a software enable can also start it. A stop-during-programming option freezes counting while non-volatile memory is busy being programmed.

Top module: `wdt_win`

## Requirements
- R1: With `clk_sel`=00 and postscale code n, the first `timeout` pulse comes exactly `2^PERIOD_LOG * 2^n` clock edges after enabling. The pulse lasts one cycle and counting restarts from zero, so the next pulse follows one full period later. `timeout` and `win_err` are never high together.
- R2: A postscale code above `PS_CODE_MAX` (default 20, i.e. 10100) behaves exactly like `PS_CODE_MAX`.
- R3: `clk_sel` 00 makes every clock cycle a tick. `clk_sel` 11 makes each cycle with `lprc_tick`=1 a tick. The unusable codes 01 and 10 supply no ticks, so the count holds.
- R4: With `win_off`=1 (standard mode) every clear is accepted and `win_err` never rises.
- R5: With `win_off`=0 the clear window is the final 75%, 50%, 37.5% or 25% of the period, for `win_code` 00, 01, 10 or 11 respectively. A clear while the count is below `PERIOD*(1-fraction)` pulses `win_err` one cycle later and leaves both counters running.
- R6: An accepted clear zeroes both the postscaler and the main counter. The next timeout then comes one full period after the clear edge.
- R7: The timer runs when `hw_en`=1 or `sw_en`=1. With both at 0 the counters are held at zero, clears are ignored and neither output rises.
- R8: With `pgm_stop`=1 and `nvm_busy`=1 both counters hold their values. With `pgm_stop`=0, `nvm_busy` has no effect.
- R9: After reset both outputs are low and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (peripheral bus clock) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lprc_tick | input | 1 | Low-power RC tick pulse, synchronous to `clk` |
| clk_sel | input | 2 | Tick source: 00 bus clock, 11 RC tick, 01/10 reserved |
| ps_code | input | PS_CODE_W | Postscale code n, division by 2^n |
| win_code | input | 2 | Clear-window size code |
| win_off | input | 1 | 1 = standard mode, 0 = windowed mode |
| hw_en | input | 1 | Hardware enable, forces the timer on |
| sw_en | input | 1 | Software enable |
| pgm_stop | input | 1 | Freeze counting while memory programming is busy |
| nvm_busy | input | 1 | Non-volatile memory programming in progress |
| kick | input | 1 | Clear strobe, one cycle |
| timeout | output | 1 | One-cycle timeout event |
| win_err | output | 1 | One-cycle early-clear event |

## Verification
Both events are registered, so each one is visible from the edge that samples its cause until the next edge. A clear driven before edge k shows `win_err` right after edge k. When counting starts with a given set of inputs, the timeout is due after exactly period-times-divider edges of enabled, unfrozen ticks. The bench drives every input at the falling edge and samples at the following falling edges. It counts edges from the enabling edge and requires that the first timeout falls on the computed edge and on no earlier one. Where the RC tick is used, the bench counts tick pulses instead of edges, and it adds frozen or disabled cycles to the expected figure.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    SEL_BUS  = 2'b00,
    SEL_RSVA = 2'b01,
    SEL_RSVB = 2'b10,
    SEL_LPRC = 2'b11
  } tick_src_e;

  // open part of the period, in eighths, per window-size code
  function automatic int unsigned open_eighths(input logic [1:0] code);
    case (code)
      2'b00:   return 6;
      2'b01:   return 4;
      2'b10:   return 3;
      default: return 2;
    endcase
  endfunction

endpackage

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel
  import wdt_pkg::*;
(
  input  logic [1:0] clk_sel,
  input  logic       lprc_tick,
  output logic       tick
);

  tick_src_e src;

  always_comb begin
    src = tick_src_e'(clk_sel);
    case (src)
      SEL_BUS:  tick = 1'b1;
      SEL_LPRC: tick = lprc_tick;
      default:  tick = 1'b0;
    endcase
  end

endmodule

// File: rtl/wdt_postscaler.sv
module wdt_postscaler #(
  parameter int CODE_MAX = 20,
  parameter int CODE_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic [CODE_W-1:0] code,
  output logic              post_tick
);

  localparam int CNT_W = CODE_MAX;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  mask;
  logic [CODE_W-1:0] code_eff;

  always_comb begin
    if (code > CODE_W'(CODE_MAX)) code_eff = CODE_W'(CODE_MAX);
    else                          code_eff = code;
  end

  for (genvar gi = 0; gi < CNT_W; gi++) begin : g_mask
    assign mask[gi] = (CODE_W'(gi) < code_eff);
  end

  assign post_tick = adv && ((cnt_q & mask) == mask);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (adv) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/wdt_window_cnt.sv
module wdt_window_cnt #(
  parameter int PERIOD_LOG = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  step,
  input  logic                  kick,
  input  logic                  win_off,
  input  logic [1:0]            win_code,
  output logic                  kick_ok,
  output logic                  timeout,
  output logic                  win_err,
  output logic [PERIOD_LOG-1:0] cnt
);

  localparam int PERIOD = 1 << PERIOD_LOG;
  localparam int EIGHTH = PERIOD / 8;
  localparam int LIM_W  = PERIOD_LOG + 1;

  logic [PERIOD_LOG-1:0] cnt_q, cnt_d;
  logic                  to_q, to_d;
  logic                  err_q, err_d;
  logic [LIM_W-1:0]      open_len, closed_lim;
  logic                  in_closed, kick_bad, wrap;

  always_comb begin
    open_len   = LIM_W'(EIGHTH * int'(wdt_pkg::open_eighths(win_code)));
    closed_lim = LIM_W'(PERIOD) - open_len;
    in_closed  = !win_off && ({1'b0, cnt_q} < closed_lim);
    kick_ok    = en && kick && !in_closed;
    kick_bad   = en && kick && in_closed;
    wrap       = step && (cnt_q == PERIOD_LOG'(PERIOD - 1));
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!en)          cnt_d = '0;
    else if (kick_ok) cnt_d = '0;
    else if (wrap)    cnt_d = '0;
    else if (step)    cnt_d = cnt_q + 1'b1;
    to_d  = en && !kick_ok && wrap;
    err_d = kick_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      to_q  <= to_d;
      err_q <= err_d;
    end
  end

  assign timeout = to_q;
  assign win_err = err_q;
  assign cnt     = cnt_q;

endmodule

// File: rtl/wdt_win.sv
module wdt_win #(
  parameter int PERIOD_LOG  = 3,
  parameter int PS_CODE_MAX = 20,
  parameter int PS_CODE_W   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lprc_tick,
  input  logic [1:0]           clk_sel,
  input  logic [PS_CODE_W-1:0] ps_code,
  input  logic [1:0]           win_code,
  input  logic                 win_off,
  input  logic                 hw_en,
  input  logic                 sw_en,
  input  logic                 pgm_stop,
  input  logic                 nvm_busy,
  input  logic                 kick,
  output logic                 timeout,
  output logic                 win_err
);

  logic [1:0]            rst_sync;
  logic                  rst_q_n;
  logic                  tick, en, frozen, adv, post_tick, kick_ok;
  logic [PERIOD_LOG-1:0] cnt_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  assign en     = hw_en || sw_en;
  assign frozen = pgm_stop && nvm_busy;
  assign adv    = tick && en && !frozen;

  wdt_tick_sel u_tick (
    .clk_sel   (clk_sel),
    .lprc_tick (lprc_tick),
    .tick      (tick)
  );

  wdt_postscaler #(
    .CODE_MAX (PS_CODE_MAX),
    .CODE_W   (PS_CODE_W)
  ) u_post (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .clr       (!en || kick_ok),
    .adv       (adv),
    .code      (ps_code),
    .post_tick (post_tick)
  );

  wdt_window_cnt #(
    .PERIOD_LOG (PERIOD_LOG)
  ) u_win (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .en       (en),
    .step     (post_tick),
    .kick     (kick),
    .win_off  (win_off),
    .win_code (win_code),
    .kick_ok  (kick_ok),
    .timeout  (timeout),
    .win_err  (win_err),
    .cnt      (cnt_w)
  );

endmodule

// File: rtl/wdt_win_chk.sv
module wdt_win_chk #(
  parameter int PERIOD_LOG = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            clk_sel,
  input logic                  win_off,
  input logic                  hw_en,
  input logic                  sw_en,
  input logic                  pgm_stop,
  input logic                  nvm_busy,
  input logic                  kick,
  input logic                  timeout,
  input logic                  win_err,
  input logic [PERIOD_LOG-1:0] cnt
);

  p_wrap_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (cnt == '0));

  p_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({timeout, win_err}));

  p_rsv_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((clk_sel == 2'b01 || clk_sel == 2'b10) && (hw_en || sw_en) && !kick)
      |=> $stable(cnt));

  p_std_no_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_off && kick) |=> !win_err);

  p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_err |-> ($past(kick) && !$past(win_off)));

  p_off_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(hw_en || sw_en) |=> (cnt == '0 && !timeout && !win_err));

  p_freeze_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_stop && nvm_busy && (hw_en || sw_en) && !kick) |=> $stable(cnt));

endmodule

bind wdt_win wdt_win_chk #(.PERIOD_LOG(PERIOD_LOG)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .clk_sel  (clk_sel),
  .win_off  (win_off),
  .hw_en    (hw_en),
  .sw_en    (sw_en),
  .pgm_stop (pgm_stop),
  .nvm_busy (nvm_busy),
  .kick     (kick),
  .timeout  (timeout),
  .win_err  (win_err),
  .cnt      (cnt_w)
);

// File: tb/wdt_win_tb.sv
module wdt_win_tb;

  localparam int CLK_P  = 10;
  localparam int PER    = 8;

  logic       clk = 1'b0;
  logic       rst_n, lprc_tick, win_off, hw_en, sw_en, pgm_stop, nvm_busy, kick;
  logic [1:0] clk_sel, win_code;
  logic [4:0] ps_code;
  logic       timeout, win_err, to_c, err_c;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  wdt_win u_dut (
    .clk(clk), .rst_n(rst_n), .lprc_tick(lprc_tick), .clk_sel(clk_sel),
    .ps_code(ps_code), .win_code(win_code), .win_off(win_off),
    .hw_en(hw_en), .sw_en(sw_en), .pgm_stop(pgm_stop), .nvm_busy(nvm_busy),
    .kick(kick), .timeout(timeout), .win_err(win_err)
  );

  wdt_win #(.PS_CODE_MAX(4)) u_dut_clamp (
    .clk(clk), .rst_n(rst_n), .lprc_tick(lprc_tick), .clk_sel(clk_sel),
    .ps_code(ps_code), .win_code(win_code), .win_off(win_off),
    .hw_en(hw_en), .sw_en(sw_en), .pgm_stop(pgm_stop), .nvm_busy(nvm_busy),
    .kick(kick), .timeout(to_c), .win_err(err_c)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // first edge (counted from the enabling edge) at which a timeout is seen
  task automatic expect_to(input int exp, input bit use_clamp, input string tag);
    int first = -1;
    for (int i = 1; i <= exp + 16; i++) begin
      @(negedge clk);
      if ((use_clamp ? to_c : timeout) && first < 0) first = i;
    end
    check(first == exp, tag, first, exp);
  endtask

  task automatic idle();
    hw_en = 1'b0; sw_en = 1'b0; kick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; lprc_tick = 1'b0; clk_sel = 2'b00; ps_code = '0;
    win_code = 2'b00; win_off = 1'b1; hw_en = 1'b0; sw_en = 1'b0;
    pgm_stop = 1'b0; nvm_busy = 1'b0; kick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!timeout && !win_err, "R9 outputs low after reset", {timeout, win_err}, 0);
  endtask

  task automatic t_period();
    ps_code = 5'd0; hw_en = 1'b1;
    expect_to(PER, 1'b0, "R1 n=0 first timeout");
    expect_to(PER, 1'b0, "R1 n=0 repeat timeout");
    idle();
    ps_code = 5'd2; sw_en = 1'b1;
    expect_to(PER * 4, 1'b0, "R1 R7 n=2 via sw_en");
    idle();
    ps_code = 5'd5; hw_en = 1'b1;
    expect_to(PER * 32, 1'b0, "R1 n=5");
    idle();
  endtask

  task automatic t_clamp();
    ps_code = 5'd31; hw_en = 1'b1;
    expect_to(PER * 16, 1'b1, "R2 code 31 acts as max");
    idle();
    ps_code = 5'd4; hw_en = 1'b1;
    expect_to(PER * 16, 1'b1, "R2 code at max");
    idle();
    ps_code = 5'd0;
  endtask

  task automatic t_lprc();
    bit bad = 1'b0;
    clk_sel = 2'b11; hw_en = 1'b1;
    for (int p = 1; p <= PER; p++) begin
      lprc_tick = 1'b1;
      @(negedge clk);
      lprc_tick = 1'b0;
      if (timeout != (p == PER)) bad = 1'b1;
      repeat (2) begin
        @(negedge clk);
        if (timeout) bad = 1'b1;
      end
    end
    check(!bad, "R3 rc tick drives count", bad, 0);
    idle();
    clk_sel = 2'b00;
  endtask

  task automatic t_reserved();
    int seen = 0;
    hw_en = 1'b1;
    clk_sel = 2'b01;
    repeat (60) begin @(negedge clk); if (timeout) seen++; end
    clk_sel = 2'b10;
    repeat (60) begin @(negedge clk); if (timeout) seen++; end
    check(seen == 0, "R3 reserved select gives no ticks", seen, 0);
    clk_sel = 2'b00;
    expect_to(PER, 1'b0, "R3 count held at zero under reserved select");
    idle();
  endtask

  // clear after k edges of counting; bad_exp tells whether it is early
  task automatic kick_at(input int k, input bit bad_exp, input string tag);
    hw_en = 1'b1;
    repeat (k) @(negedge clk);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    check(win_err == bad_exp, {tag, " error flag"}, win_err, bad_exp);
    if (bad_exp) expect_to(PER - (k + 1), 1'b0, {tag, " timeout unchanged"});
    else         expect_to(PER, 1'b0, {tag, " timeout restarted"});
    idle();
  endtask

  task automatic t_window();
    win_off = 1'b0;
    win_code = 2'b00; kick_at(1, 1'b1, "R5 75% early");
    win_code = 2'b00; kick_at(2, 1'b0, "R5 R6 75% open");
    win_code = 2'b01; kick_at(3, 1'b1, "R5 50% early");
    win_code = 2'b01; kick_at(4, 1'b0, "R5 R6 50% open");
    win_code = 2'b10; kick_at(4, 1'b1, "R5 37.5% early");
    win_code = 2'b10; kick_at(5, 1'b0, "R5 R6 37.5% open");
    win_code = 2'b11; kick_at(5, 1'b1, "R5 25% early");
    win_code = 2'b11; kick_at(6, 1'b0, "R5 R6 25% open");
    win_off = 1'b1;
  endtask

  task automatic t_standard();
    win_off = 1'b1; win_code = 2'b11;
    kick_at(1, 1'b0, "R4 standard early clear accepted");
    ps_code = 5'd2; hw_en = 1'b1;
    repeat (6) @(negedge clk);
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
    expect_to(PER * 4, 1'b0, "R6 clear zeroes postscaler");
    idle();
    ps_code = 5'd0;
  endtask

  task automatic t_disable();
    int seen = 0;
    hw_en = 1'b1;
    repeat (5) @(negedge clk);
    hw_en = 1'b0;
    win_off = 1'b0;
    repeat (20) begin
      kick = 1'b1;
      @(negedge clk);
      kick = 1'b0;
      @(negedge clk);
      if (timeout || win_err) seen++;
    end
    check(seen == 0, "R7 disabled: no events, clears ignored", seen, 0);
    win_off = 1'b1;
    hw_en = 1'b1;
    expect_to(PER, 1'b0, "R7 count cleared while disabled");
    idle();
  endtask

  task automatic t_freeze();
    hw_en = 1'b1;
    repeat (3) @(negedge clk);
    pgm_stop = 1'b1; nvm_busy = 1'b1;
    repeat (10) @(negedge clk);
    check(!timeout, "R8 frozen no timeout", timeout, 0);
    nvm_busy = 1'b0;
    expect_to(PER - 3, 1'b0, "R8 resumes from held count");
    idle();
    pgm_stop = 1'b0; nvm_busy = 1'b1; hw_en = 1'b1;
    expect_to(PER, 1'b0, "R8 busy ignored without stop bit");
    idle();
    nvm_busy = 1'b0;
  endtask

  initial begin
    t_reset();
    t_period();
    t_clamp();
    t_lprc();
    t_reserved();
    t_window();
    t_standard();
    t_disable();
    t_freeze();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule